// File: doc/BRIEF.md
# Shared Time-Base Counter Fabric

This block generates and distributes the time bases for a bank of 32 timer channels. Every channel owns a 16-bit free-running counter. Each counter advances behind two divide stages: one global divider common to the whole bank, then a divider private to the channel. Five of these counters are also published as shared counter buses. One bus is visible to every channel. Each of the other four is visible only inside one group of eight consecutive channels. Each channel then selects the count it presents: the bank-wide bus, its group's bus, or its own counter.

A single global enable bit gates every counter and divider at once. While the bit is low, all divider phases are held at zero, so every time base starts from the same phase on the same edge. A module-disable bit freezes all counting while the register port stays usable. A per-channel freeze-enable bit, combined with a shared debug input, halts individual counters while the others keep running. Software reaches the block through a simple write port and a combinational read port. Downstream logic uses the per-channel selected count.

Top module: `tbase_fabric`

## Requirements
- R1: After reset, every counter, every divider phase and every register is zero, so all selected counts read 0 and address 0 reads 0.
- R2: While running, a counter advances by exactly one every (G+1)*(C+1) cycles. G is the global ratio (address 0, bits 3:2) and C is the channel ratio (channel config bits 3:2), each ranging 0..3.
- R3: The global enable is address 0 bit 0. While it is low, counters hold and all divider phases are cleared. When it is written to 1, every counter whose ratios are both 0 advances on the first edge after the edge that stored the bit, all on that same edge.
- R4: Channel select code 00 (config bits 1:0) presents the counter of channel 23 (bus A) on that channel's selected count.
- R5: Select code 01 presents the counter of the first channel of the channel's group of eight: channel 0, 8, 16 or 24 for channels 0-7, 8-15, 16-23 and 24-31.
- R6: Select codes 10 and 11 both present the channel's own counter.
- R7: When a channel's freeze bit (config bit 4) is set and dbg_req is high, that channel's counter and divider hold, while channels without the bit keep counting.
- R8: Module disable (address 0 bit 1) stops all counters and dividers. Register writes, including counter loads, and reads still take effect while it is set.
- R9: A counter at 0xFFFF advances to 0x0000.
- R10: Channel config sits at address 0x40+2*ch and the channel counter at 0x41+2*ch, both readable. A counter write loads the value on the next edge and takes priority over an advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_req | input | 1 | Debug request, halts channels whose freeze bit is set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| sel_count | output | 512 | Selected count of each channel, channel n at bits 16n+15:16n |

## Verification
Two things can fall on the same edge: a software load of a counter and that counter's own advance. Likewise, a shared bus driver can advance while another channel changes its select code to that bus. The bench provokes the first pair directly by writing a counter while it runs with ratio 1, and expects the written value rather than the written value plus one. Random traffic keeps mixing config rewrites, counter loads, enable, disable and debug toggles with running counters. Every selected count is compared each cycle against a cycle-level reference model held in the bench.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    parameter int NCH      = 32;
    parameter int GRP      = 8;
    parameter int BUS_A_CH = 23;
    parameter int CNT_W    = 16;
    parameter int PS_W     = 2;
    parameter int SEL_W    = 2;
    localparam int CH_W    = $clog2(NCH);
    localparam int ADDR_W  = CH_W + 2;
    localparam int NGRP    = NCH / GRP;

    typedef enum logic [SEL_W-1:0] {
        SEL_BUS_A = 2'b00,
        SEL_GRP   = 2'b01,
        SEL_OWN   = 2'b10,
        SEL_RSV   = 2'b11
    } tb_sel_e;

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    typedef struct packed {
        logic             frz;
        logic [PS_W-1:0]  div;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    typedef struct packed {
        logic [PS_W-1:0] gdiv;
        logic            mdis;
        logic            gen;
    } glob_cfg_t;

    localparam int GLB_W = $bits(glob_cfg_t);
    localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/tbase_gpresc.sv
module tbase_gpresc
    import tbase_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] div,
    input  logic            run,
    input  logic            clr,
    output logic            gtick
);
    logic [PS_W-1:0] gp_d, gp_q;

    always_comb begin
        gp_d  = gp_q;
        gtick = run && (gp_q == div);
        if (clr) begin
            gp_d = '0;
        end else if (run) begin
            gp_d = gtick ? '0 : gp_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gp_q <= '0;
        else        gp_q <= gp_d;
    end
endmodule

// File: rtl/tbase_chan.sv
module tbase_chan
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [PS_W-1:0]  div,
    input  logic             frz,
    input  logic             clr,
    input  logic             gtick,
    output logic [CNT_W-1:0] cnt_o
);
    chan_st_t st_d, st_q;
    logic     adv;

    always_comb begin
        st_d = st_q;
        adv  = gtick && !frz;
        if (clr) begin
            st_d.ps = '0;
        end else if (adv) begin
            if (st_q.ps == div) begin
                st_d.ps  = '0;
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.ps = st_q.ps + 1'b1;
            end
        end
        if (ld_en) st_d.cnt = ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/tbase_busmux.sv
module tbase_busmux
    import tbase_pkg::*;
(
    input  logic [NCH-1:0][CNT_W-1:0] cnt_i,
    input  logic [NCH-1:0][SEL_W-1:0] sel_i,
    output logic [NCH-1:0][CNT_W-1:0] cnt_o
);
    logic [NGRP-1:0][CNT_W-1:0] gbus;
    logic [CNT_W-1:0]           bus_a;

    assign bus_a = cnt_i[BUS_A_CH];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign gbus[g] = cnt_i[g*GRP];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        always_comb begin
            unique case (tb_sel_e'(sel_i[i]))
                SEL_BUS_A: cnt_o[i] = bus_a;
                SEL_GRP:   cnt_o[i] = gbus[i/GRP];
                SEL_OWN,
                SEL_RSV:   cnt_o[i] = cnt_i[i];
                default:   cnt_o[i] = cnt_i[i];
            endcase
        end
    end
endmodule

// File: rtl/tbase_fabric.sv
module tbase_fabric
    import tbase_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dbg_req,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CNT_W-1:0]       rd_data,
    output logic [NCH*CNT_W-1:0]   sel_count
);
    typedef struct packed {
        glob_cfg_t                 g;
        chan_cfg_t [NCH-1:0]       c;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                          gen_en, mod_off, run, clr, gtick;
    logic [NCH-1:0]                frz_cfg, ld_en;
    logic [NCH-1:0][SEL_W-1:0]     sel_cfg;
    logic [NCH-1:0][CNT_W-1:0]     cnt_a, mux_o;
    logic                          wr_chan, rd_chan;
    logic [CH_W-1:0]               wr_ch, rd_ch;

    assign wr_chan = wr_addr[ADDR_W-1];
    assign wr_ch   = wr_addr[ADDR_W-2:1];
    assign rd_chan = rd_addr[ADDR_W-1];
    assign rd_ch   = rd_addr[ADDR_W-2:1];

    // register write path
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == '0) begin
                regs_d.g = glob_cfg_t'(wr_data[GLB_W-1:0]);
            end else if (wr_chan && !wr_addr[0]) begin
                regs_d.c[wr_ch] = chan_cfg_t'(wr_data[CFG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign gen_en  = regs_q.g.gen;
    assign mod_off = regs_q.g.mdis;
    assign run     = gen_en && !mod_off;
    assign clr     = !gen_en && !mod_off;

    tbase_gpresc u_gp (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (regs_q.g.gdiv),
        .run   (run),
        .clr   (clr),
        .gtick (gtick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign frz_cfg[i] = regs_q.c[i].frz;
        assign sel_cfg[i] = regs_q.c[i].sel;
        assign ld_en[i]   = wr_en && wr_chan && wr_addr[0] && (wr_ch == CH_W'(i));

        tbase_chan u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_en  (ld_en[i]),
            .ld_val (wr_data),
            .div    (regs_q.c[i].div),
            .frz    (frz_cfg[i] && dbg_req),
            .clr    (clr),
            .gtick  (gtick),
            .cnt_o  (cnt_a[i])
        );
    end

    tbase_busmux u_mux (
        .cnt_i (cnt_a),
        .sel_i (sel_cfg),
        .cnt_o (mux_o)
    );

    assign sel_count = mux_o;

    // register read path
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[GLB_W-1:0] = regs_q.g;
        end else if (rd_chan) begin
            if (rd_addr[0]) rd_data = cnt_a[rd_ch];
            else            rd_data[CFG_W-1:0] = regs_q.c[rd_ch];
        end
    end
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk
    import tbase_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      dbg_req,
    input logic                      gen_en,
    input logic                      mod_off,
    input logic [NCH-1:0]            frz_cfg,
    input logic [NCH-1:0][SEL_W-1:0] sel_cfg,
    input logic [NCH-1:0][CNT_W-1:0] cnt_a,
    input logic [NCH-1:0][CNT_W-1:0] sel_count
);
    assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_off && !wr_en) |=> $stable(cnt_a));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !wr_en) |=> $stable(cnt_a));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_frz_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (frz_cfg[i] && dbg_req && !wr_en) |=> $stable(cnt_a[i]));

        assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (cnt_a[i] == $past(cnt_a[i]) ||
                        cnt_a[i] == CNT_W'($past(cnt_a[i]) + 1'b1)));

        assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && cnt_a[i] == '1) |=> (cnt_a[i] == '1 || cnt_a[i] == '0));

        assert_bus_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_cfg[i] == 2'b00) |-> (sel_count[i] == cnt_a[BUS_A_CH]));

        assert_grp_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_cfg[i] == 2'b01) |-> (sel_count[i] == cnt_a[(i/GRP)*GRP]));

        assert_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sel_cfg[i][1] |-> (sel_count[i] == cnt_a[i]));
    end
endmodule

bind tbase_fabric tbase_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .dbg_req   (dbg_req),
    .gen_en    (gen_en),
    .mod_off   (mod_off),
    .frz_cfg   (frz_cfg),
    .sel_cfg   (sel_cfg),
    .cnt_a     (cnt_a),
    .sel_count (mux_o)
);

// File: tb/sim_tbase_fabric.sv
module sim_tbase_fabric;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg_req = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [6:0]    rd_addr = '0;
    logic [15:0]   rd_data;
    logic [N*16-1:0] sel_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    logic [15:0] m_cnt [N];
    logic [1:0]  m_ps  [N];
    logic [1:0]  m_sel [N];
    logic [1:0]  m_div [N];
    logic        m_frz [N];
    logic [1:0]  m_gp, m_gdiv;
    logic        m_gen, m_mdis;

    tbase_fabric u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_req   (dbg_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sel_count (sel_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cyc);
            summary();
        end
    end

    function automatic logic [6:0] cfg_addr(int ch);
        return 7'h40 | 7'(ch << 1);
    endfunction

    function automatic logic [6:0] cnt_addr(int ch);
        return cfg_addr(ch) | 7'h1;
    endfunction

    function automatic logic [15:0] got_sel(int ch);
        return sel_count[ch*16 +: 16];
    endfunction

    function automatic logic [15:0] exp_sel(int ch);
        case (m_sel[ch])
            2'b00:   return m_cnt[23];
            2'b01:   return m_cnt[(ch/8)*8];
            default: return m_cnt[ch];
        endcase
    endfunction

    task automatic check(string req, int ch, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ch %0d: got %h exp %h", req, ch, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = '0; m_ps[i] = '0; m_sel[i] = '0; m_div[i] = '0; m_frz[i] = 1'b0;
        end
        m_gp = '0; m_gdiv = '0; m_gen = 1'b0; m_mdis = 1'b0;
    endtask

    task automatic model_update(bit we, logic [6:0] wa, logic [15:0] wd, bit dbg);
        bit gt;
        gt = m_gen && !m_mdis && (m_gp == m_gdiv);
        for (int i = 0; i < N; i++) begin
            if (!m_mdis && !m_gen) m_ps[i] = '0;
            else if (gt && !(m_frz[i] && dbg)) begin
                if (m_ps[i] == m_div[i]) begin
                    m_ps[i] = '0;
                    m_cnt[i] = m_cnt[i] + 16'd1;
                end else m_ps[i] = m_ps[i] + 2'd1;
            end
        end
        if (!m_mdis) m_gp = !m_gen ? 2'd0 : (gt ? 2'd0 : m_gp + 2'd1);
        if (we) begin
            if (wa == 7'h0) begin
                m_gen = wd[0]; m_mdis = wd[1]; m_gdiv = wd[3:2];
            end else if (wa[6]) begin
                if (wa[0]) m_cnt[wa[5:1]] = wd;
                else begin
                    m_sel[wa[5:1]] = wd[1:0];
                    m_div[wa[5:1]] = wd[3:2];
                    m_frz[wa[5:1]] = wd[4];
                end
            end
        end
    endtask

    task automatic step(bit we, logic [6:0] wa, logic [15:0] wd);
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        model_update(we, wa, wd, dbg_req);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 7'h0, 16'h0);
    endtask

    task automatic check_model(string req);
        for (int i = 0; i < N; i++) check(req, i, got_sel(i), exp_sel(i));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);

        // R1: reset state
        for (int i = 0; i < N; i++) check("R1", i, got_sel(i), 16'h0);
        rd_addr = 7'h0; #1;
        check("R1", -1, rd_data, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: simultaneous start, all ratios 1, own counter
        for (int i = 0; i < N; i++) step(1'b1, cfg_addr(i), 16'h0002);
        step(1'b1, 7'h0, 16'h0001);
        for (int i = 0; i < N; i++) check("R3", i, got_sel(i), 16'h0);
        idle(1);
        for (int i = 0; i < N; i++) check("R3", i, got_sel(i), 16'h1);

        // R4 R5 R6 R10: bus routing with distinct counter values
        step(1'b1, 7'h0, 16'h0000);
        for (int i = 0; i < N; i++) step(1'b1, cnt_addr(i), 16'(i*257 + 17));
        for (int i = 0; i < N; i++) step(1'b1, cfg_addr(i), 16'(i % 4));
        idle(2);
        for (int i = 0; i < N; i++) begin
            case (i % 4)
                0: check("R4", i, got_sel(i), 16'(23*257 + 17));
                1: check("R5", i, got_sel(i), 16'(((i/8)*8)*257 + 17));
                default: check("R6", i, got_sel(i), 16'(i*257 + 17));
            endcase
        end
        rd_addr = cnt_addr(9); #1;
        check("R10", 9, rd_data, 16'(9*257 + 17));
        rd_addr = cfg_addr(7); #1;
        check("R10", 7, rd_data, 16'h0003);

        // R7: freeze odd channels under debug
        for (int i = 0; i < N; i++) step(1'b1, cnt_addr(i), 16'h0);
        for (int i = 0; i < N; i++) step(1'b1, cfg_addr(i), (i % 2) ? 16'h0012 : 16'h0002);
        dbg_req = 1'b1;
        step(1'b1, 7'h0, 16'h0001);
        idle(20);
        for (int i = 0; i < N; i++) check("R7", i, got_sel(i), (i % 2) ? 16'd0 : 16'd20);
        dbg_req = 1'b0;
        idle(3);
        for (int i = 0; i < N; i++) check("R7", i, got_sel(i), (i % 2) ? 16'd3 : 16'd23);

        // R8: module disable holds counts, port still works
        step(1'b1, 7'h0, 16'h0003);
        idle(10);
        for (int i = 0; i < N; i++) check("R8", i, got_sel(i), (i % 2) ? 16'd4 : 16'd24);
        step(1'b1, cnt_addr(5), 16'h1234);
        idle(4);
        rd_addr = cnt_addr(5); #1;
        check("R8", 5, rd_data, 16'h1234);
        check("R8", 5, got_sel(5), 16'h1234);
        step(1'b1, 7'h0, 16'h0000);

        // R9: wrap, R10: load beats advance
        step(1'b1, cnt_addr(3), 16'hFFFF);
        step(1'b1, 7'h0, 16'h0001);
        idle(1);
        check("R9", 3, got_sel(3), 16'h0000);
        step(1'b1, cnt_addr(4), 16'h0050);
        check("R10", 4, got_sel(4), 16'h0050);
        check_model("R10");

        // R2: ratios, global divide 3, channel ratio i%4
        step(1'b1, 7'h0, 16'h0000);
        for (int i = 0; i < N; i++) step(1'b1, cnt_addr(i), 16'h0);
        for (int i = 0; i < N; i++) step(1'b1, cfg_addr(i), 16'(((i % 4) << 2) | 2));
        step(1'b1, 7'h0, 16'h0009);
        idle(48);
        for (int i = 0; i < N; i++) check("R2", i, got_sel(i), 16'(48 / (3 * ((i % 4) + 1))));

        // random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10 against the model
        for (int k = 0; k < 3000; k++) begin
            int r;
            int ch;
            r  = $urandom_range(0, 99);
            ch = $urandom_range(0, N-1);
            if ($urandom_range(0, 9) == 0) dbg_req = ~dbg_req;
            if (r < 4)
                step(1'b1, 7'h0, 16'({$urandom_range(0, 3), ($urandom_range(0, 7) == 0), ($urandom_range(0, 4) != 0)}));
            else if (r < 30)
                step(1'b1, cfg_addr(ch), 16'($urandom_range(0, 31)));
            else if (r < 38)
                step(1'b1, cnt_addr(ch), ($urandom_range(0, 3) == 0) ? 16'hFFFE : 16'($urandom_range(0, 65535)));
            else
                step(1'b0, 7'h0, 16'h0);
            check_model("R2");
        end

        summary();
    end
endmodule